// File: doc/BRIEF.md
# Power-Sourcing Port Sequencer

This block is the control state machine for one power-sourcing port. It takes a port from rest, through signature detection and classification, asks the budget allocator for power, turns the gate on behind a high-current inrush window, and then watches the maintain-power signature. Overcurrent, a missing signature, a refused grant and a disable each have a defined exit. All measurements arrive as digital results from the analog front end. The block only decides when the switch element is on, which current limit applies, and what gets recorded.

States and their codes: IDLE (0), DETECT (1), CLASS (2), POWER_ON (3), MPS_MON (4), FAULT (5). Transitions:
- enable: IDLE to DETECT.
- signature pass: DETECT to CLASS.
- signature fail: DETECT to IDLE.
- class accept: CLASS to POWER_ON.
- class reject: CLASS to IDLE.
- grant refuse: POWER_ON (gate off) to IDLE.
- inrush expiry: POWER_ON (gate on) to MPS_MON.
- overload trip: POWER_ON (gate on) or MPS_MON to FAULT.
- signature loss: MPS_MON to IDLE.
- hiccup retry: FAULT to DETECT.
- operator clear: FAULT to IDLE.
- disable: any state to IDLE.

The overcurrent policy input selects between hiccup retry and latch-off. Four saturating counters and two reason registers keep telemetry. All timers are synchronous down-counters whose lengths are parameters in clock ticks.

Top module: `poe_port_seq`

## Requirements
- R1: After reset the state code is 0 (IDLE), gate_on and ilim_high are 0, all four counters are 0, last_fail is 0 and off_reason is 0.
- R2: With port_en high, IDLE moves to DETECT (code 1) on the next clock. In DETECT, a det_done pulse with det_ok high moves the port to CLASS (code 2).
- R3: In DETECT, a det_done pulse with det_ok low returns the port to IDLE, increments det_fail_cnt and sets last_fail to 1.
- R4: In CLASS, a cls_done pulse with cls_code from 0 to 8 stores the code in class_q and cls_two_event in two_event_q, and moves the port to POWER_ON (code 3). A code above 8 returns the port to IDLE, increments cls_fail_cnt and sets last_fail to 2.
- R5: In POWER_ON the gate stays off until grant_valid is seen. With grant_ok high the gate turns on. With grant_ok low the port returns to IDLE with last_fail 3 and off_reason 3 (budget denied).
- R6: After a grant is accepted, gate_on and ilim_high are both 1 for exactly INRUSH_TICKS cycles in POWER_ON. The port then enters MPS_MON (code 4) with gate_on 1 and ilim_high 0.
- R7: In MPS_MON every mps_seen pulse restarts a window of MPS_WIN_TICKS cycles. If the window runs out with no pulse, the port goes to IDLE with the gate off, off_reason 1 (signature lost) and last_fail 4.
- R8: oc_trip while the gate is on moves the port to FAULT (code 5) with the gate off. It increments trip_cnt, sets off_reason to 2 (overload) and sets last_fail to the state code in which the trip occurred (3 or 4).
- R9: With retry_mode high and retries left, FAULT lasts RETRY_TICKS cycles and then moves to DETECT, incrementing retry_cnt.
- R10: After MAX_RETRY hiccup retries, or with retry_mode low, FAULT holds until fault_clear. fault_clear moves the port to IDLE and restores the full retry allowance.
- R11: port_en low forces IDLE with the gate off on the next clock edge, and the port stays in IDLE while port_en remains low.
- R12: Every counter saturates at 2^CNT_W-1 and never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_en | input | 1 | Port enable; low forces IDLE |
| det_done | input | 1 | Detection result strobe |
| det_ok | input | 1 | Detection signature valid |
| cls_done | input | 1 | Classification result strobe |
| cls_code | input | 4 | Class result, legal 0 to 8 |
| cls_two_event | input | 1 | Two-event classification was used |
| oc_trip | input | 1 | Overcurrent comparator output |
| mps_seen | input | 1 | Maintain-power signature pulse |
| grant_valid | input | 1 | Budget allocator answer strobe |
| grant_ok | input | 1 | Budget allocator answer: 1 granted |
| fault_clear | input | 1 | Leave FAULT |
| retry_mode | input | 1 | 1 hiccup retry, 0 latch-off |
| gate_on | output | 1 | Switch element enable |
| ilim_high | output | 1 | Select the inrush current limit |
| state_code | output | 3 | Current state code |
| class_q | output | 4 | Last accepted class |
| two_event_q | output | 1 | Last accepted two-event flag |
| last_fail | output | 3 | State code of the last failing stage, 0 none |
| off_reason | output | 2 | Last power-off reason: 0 none, 1 signature lost, 2 overload, 3 budget denied |
| det_fail_cnt | output | CNT_W | Detection failures |
| cls_fail_cnt | output | CNT_W | Classification failures |
| trip_cnt | output | CNT_W | Overload trips |
| retry_cnt | output | CNT_W | Hiccup retries |

## Verification
Some properties hold on every cycle, and the bound checker checks those. The gate is on only in POWER_ON or MPS_MON, and the inrush limit is selected only while the gate is on in POWER_ON. Disable wins within one edge. POWER_ON is entered only from CLASS on a legal class code. Every entry into FAULT moves the trip counter unless it is saturated. The counters never decrease, and the state and class codes stay in range. Other behaviour depends on timer lengths and event order, and only the directed scenarios can show it: the exact inrush and retry durations, the restart of the signature window on each pulse, how retries run out and when the port latches, the restored allowance after a clear, and the recorded failing stage and off reason on each exit path.

// File: rtl/poe_seq_pkg.sv
package poe_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_DETECT = 3'd1,
        ST_CLASS  = 3'd2,
        ST_POWER  = 3'd3,
        ST_MPS    = 3'd4,
        ST_FAULT  = 3'd5
    } port_state_e;

    typedef enum logic [1:0] {
        OFF_NONE     = 2'd0,
        OFF_MPS_LOST = 2'd1,
        OFF_OVERLOAD = 2'd2,
        OFF_DENIED   = 2'd3
    } off_reason_e;

    // event vector layout toward the telemetry counters
    localparam int EVT_NUM   = 4;
    localparam int EVT_DET   = 0;
    localparam int EVT_CLS   = 1;
    localparam int EVT_TRIP  = 2;
    localparam int EVT_RETRY = 3;

    localparam logic [3:0] CLASS_MAX = 4'd8;

endpackage

// File: rtl/poe_down_timer.sv
module poe_down_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);

    logic [W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (load) begin
            count_q <= load_val;
        end else if (count_q != '0) begin
            count_q <= count_q - 1'b1;
        end
    end

    assign zero = (count_q == '0);

endmodule

// File: rtl/poe_sat_counter.sv
module poe_sat_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] value
);

    localparam logic [W-1:0] TOP = '1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= '0;
        end else if (inc && value != TOP) begin
            value <= value + 1'b1;
        end
    end

endmodule

// File: rtl/poe_port_fsm.sv
module poe_port_fsm
    import poe_seq_pkg::*;
#(
    parameter int unsigned TMR_W         = 8,
    parameter int unsigned INRUSH_TICKS  = 16,
    parameter int unsigned MPS_WIN_TICKS = 64,
    parameter int unsigned RETRY_TICKS   = 32,
    parameter int unsigned MAX_RETRY     = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                port_en,
    input  logic                det_done,
    input  logic                det_ok,
    input  logic                cls_done,
    input  logic [3:0]          cls_code,
    input  logic                cls_two_event,
    input  logic                oc_trip,
    input  logic                mps_seen,
    input  logic                grant_valid,
    input  logic                grant_ok,
    input  logic                fault_clear,
    input  logic                retry_mode,
    input  logic                tmr_zero,
    output logic                tmr_load,
    output logic [TMR_W-1:0]    tmr_val,
    output logic [EVT_NUM-1:0]  evt,
    output logic                gate_on,
    output logic                ilim_high,
    output port_state_e         state,
    output logic [3:0]          class_q,
    output logic                two_event_q,
    output logic [2:0]          last_fail,
    output off_reason_e         off_reason
);

    localparam int unsigned RW = (MAX_RETRY < 1) ? 1 : $clog2(MAX_RETRY + 1);
    localparam logic [RW-1:0]    RETRY_LIMIT = RW'(MAX_RETRY);
    localparam logic [TMR_W-1:0] LD_INRUSH   = TMR_W'(INRUSH_TICKS - 1);
    localparam logic [TMR_W-1:0] LD_MPS      = TMR_W'(MPS_WIN_TICKS - 1);
    localparam logic [TMR_W-1:0] LD_RETRY    = TMR_W'(RETRY_TICKS - 1);

    port_state_e st_q, st_d;
    logic [RW-1:0] retry_used_q;
    logic          retries_left;

    logic          grant_acc;
    logic          fail_set;
    logic [2:0]    fail_val;
    logic          reason_set;
    off_reason_e   reason_val;
    logic          class_cap;
    logic          retry_take;
    logic          retry_reset;
    logic          gate_d;
    logic          ilim_d;

    assign retries_left = (retry_used_q < RETRY_LIMIT);
    assign state        = st_q;

    // next state and event decode
    always_comb begin
        st_d        = st_q;
        evt         = '0;
        grant_acc   = 1'b0;
        fail_set    = 1'b0;
        fail_val    = 3'd0;
        reason_set  = 1'b0;
        reason_val  = OFF_NONE;
        class_cap   = 1'b0;
        retry_take  = 1'b0;
        retry_reset = 1'b0;
        if (!port_en) begin
            st_d        = ST_IDLE;
            retry_reset = 1'b1;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    st_d = ST_DETECT;
                end
                ST_DETECT: begin
                    if (det_done) begin
                        if (det_ok) begin
                            st_d = ST_CLASS;
                        end else begin
                            st_d          = ST_IDLE;
                            evt[EVT_DET]  = 1'b1;
                            fail_set      = 1'b1;
                            fail_val      = ST_DETECT;
                        end
                    end
                end
                ST_CLASS: begin
                    if (cls_done) begin
                        if (cls_code <= CLASS_MAX) begin
                            st_d      = ST_POWER;
                            class_cap = 1'b1;
                        end else begin
                            st_d         = ST_IDLE;
                            evt[EVT_CLS] = 1'b1;
                            fail_set     = 1'b1;
                            fail_val     = ST_CLASS;
                        end
                    end
                end
                ST_POWER: begin
                    if (!gate_on) begin
                        if (grant_valid) begin
                            if (grant_ok) begin
                                grant_acc = 1'b1;
                            end else begin
                                st_d       = ST_IDLE;
                                fail_set   = 1'b1;
                                fail_val   = ST_POWER;
                                reason_set = 1'b1;
                                reason_val = OFF_DENIED;
                            end
                        end
                    end else if (oc_trip) begin
                        st_d          = ST_FAULT;
                        evt[EVT_TRIP] = 1'b1;
                        fail_set      = 1'b1;
                        fail_val      = ST_POWER;
                        reason_set    = 1'b1;
                        reason_val    = OFF_OVERLOAD;
                    end else if (tmr_zero) begin
                        st_d = ST_MPS;
                    end
                end
                ST_MPS: begin
                    if (oc_trip) begin
                        st_d          = ST_FAULT;
                        evt[EVT_TRIP] = 1'b1;
                        fail_set      = 1'b1;
                        fail_val      = ST_MPS;
                        reason_set    = 1'b1;
                        reason_val    = OFF_OVERLOAD;
                    end else if (tmr_zero && !mps_seen) begin
                        st_d       = ST_IDLE;
                        fail_set   = 1'b1;
                        fail_val   = ST_MPS;
                        reason_set = 1'b1;
                        reason_val = OFF_MPS_LOST;
                    end
                end
                ST_FAULT: begin
                    if (fault_clear) begin
                        st_d        = ST_IDLE;
                        retry_reset = 1'b1;
                    end else if (retry_mode && retries_left && tmr_zero) begin
                        st_d           = ST_DETECT;
                        evt[EVT_RETRY] = 1'b1;
                        retry_take     = 1'b1;
                    end
                end
                default: begin
                    st_d = ST_IDLE;
                end
            endcase
        end
    end

    // shared timer: one window is live per state
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = '0;
        if (grant_acc) begin
            tmr_load = 1'b1;
            tmr_val  = LD_INRUSH;
        end else if (st_d == ST_MPS && (st_q != ST_MPS || mps_seen)) begin
            tmr_load = 1'b1;
            tmr_val  = LD_MPS;
        end else if (st_d == ST_FAULT && st_q != ST_FAULT) begin
            tmr_load = 1'b1;
            tmr_val  = LD_RETRY;
        end
    end

    assign gate_d = (st_d == ST_MPS) || (st_d == ST_POWER && (gate_on || grant_acc));
    assign ilim_d = (st_d == ST_POWER) && gate_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // registered outputs and records
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_on      <= 1'b0;
            ilim_high    <= 1'b0;
            class_q      <= '0;
            two_event_q  <= 1'b0;
            last_fail    <= '0;
            off_reason   <= OFF_NONE;
            retry_used_q <= '0;
        end else begin
            gate_on   <= gate_d;
            ilim_high <= ilim_d;
            if (class_cap) begin
                class_q     <= cls_code;
                two_event_q <= cls_two_event;
            end
            if (fail_set) begin
                last_fail <= fail_val;
            end
            if (reason_set) begin
                off_reason <= reason_val;
            end
            if (retry_reset) begin
                retry_used_q <= '0;
            end else if (retry_take) begin
                retry_used_q <= retry_used_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/poe_port_seq.sv
module poe_port_seq
    import poe_seq_pkg::*;
#(
    parameter int unsigned CNT_W         = 8,
    parameter int unsigned INRUSH_TICKS  = 6000,
    parameter int unsigned MPS_WIN_TICKS = 32000000,
    parameter int unsigned RETRY_TICKS   = 100000000,
    parameter int unsigned MAX_RETRY     = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             port_en,
    input  logic             det_done,
    input  logic             det_ok,
    input  logic             cls_done,
    input  logic [3:0]       cls_code,
    input  logic             cls_two_event,
    input  logic             oc_trip,
    input  logic             mps_seen,
    input  logic             grant_valid,
    input  logic             grant_ok,
    input  logic             fault_clear,
    input  logic             retry_mode,
    output logic             gate_on,
    output logic             ilim_high,
    output logic [2:0]       state_code,
    output logic [3:0]       class_q,
    output logic             two_event_q,
    output logic [2:0]       last_fail,
    output logic [1:0]       off_reason,
    output logic [CNT_W-1:0] det_fail_cnt,
    output logic [CNT_W-1:0] cls_fail_cnt,
    output logic [CNT_W-1:0] trip_cnt,
    output logic [CNT_W-1:0] retry_cnt
);

    localparam int unsigned MAX_AB  = (INRUSH_TICKS > MPS_WIN_TICKS) ? INRUSH_TICKS : MPS_WIN_TICKS;
    localparam int unsigned TMR_MAX = (MAX_AB > RETRY_TICKS) ? MAX_AB : RETRY_TICKS;
    localparam int unsigned TMR_W   = (TMR_MAX < 2) ? 1 : $clog2(TMR_MAX);

    logic               tmr_load;
    logic [TMR_W-1:0]   tmr_val;
    logic               tmr_zero;
    logic [EVT_NUM-1:0] evt;
    logic [CNT_W-1:0]   cnt_bank [EVT_NUM];
    port_state_e        st;
    off_reason_e        reason;

    poe_port_fsm #(
        .TMR_W         (TMR_W),
        .INRUSH_TICKS  (INRUSH_TICKS),
        .MPS_WIN_TICKS (MPS_WIN_TICKS),
        .RETRY_TICKS   (RETRY_TICKS),
        .MAX_RETRY     (MAX_RETRY)
    ) fsm_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .port_en       (port_en),
        .det_done      (det_done),
        .det_ok        (det_ok),
        .cls_done      (cls_done),
        .cls_code      (cls_code),
        .cls_two_event (cls_two_event),
        .oc_trip       (oc_trip),
        .mps_seen      (mps_seen),
        .grant_valid   (grant_valid),
        .grant_ok      (grant_ok),
        .fault_clear   (fault_clear),
        .retry_mode    (retry_mode),
        .tmr_zero      (tmr_zero),
        .tmr_load      (tmr_load),
        .tmr_val       (tmr_val),
        .evt           (evt),
        .gate_on       (gate_on),
        .ilim_high     (ilim_high),
        .state         (st),
        .class_q       (class_q),
        .two_event_q   (two_event_q),
        .last_fail     (last_fail),
        .off_reason    (reason)
    );

    poe_down_timer #(.W(TMR_W)) tmr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    for (genvar g = 0; g < EVT_NUM; g++) begin : g_cnt
        poe_sat_counter #(.W(CNT_W)) cnt_i (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (evt[g]),
            .value (cnt_bank[g])
        );
    end

    assign state_code   = st;
    assign off_reason   = reason;
    assign det_fail_cnt = cnt_bank[EVT_DET];
    assign cls_fail_cnt = cnt_bank[EVT_CLS];
    assign trip_cnt     = cnt_bank[EVT_TRIP];
    assign retry_cnt    = cnt_bank[EVT_RETRY];

endmodule

// File: rtl/poe_port_seq_chk.sv
module poe_port_seq_chk #(
    parameter int unsigned CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             port_en,
    input logic             cls_done,
    input logic [3:0]       cls_code,
    input logic             gate_on,
    input logic             ilim_high,
    input logic [2:0]       state_code,
    input logic [3:0]       class_q,
    input logic [CNT_W-1:0] det_fail_cnt,
    input logic [CNT_W-1:0] trip_cnt,
    input logic [CNT_W-1:0] retry_cnt
);

    // R8
    gate_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gate_on |-> (state_code == 3'd3 || state_code == 3'd4));

    // R6
    inrush_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ilim_high |-> (gate_on && state_code == 3'd3));

    // R11
    disable_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !port_en |=> (state_code == 3'd0 && !gate_on));

    // R4
    power_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 3'd3 && $past(state_code) != 3'd3)
            |-> ($past(state_code) == 3'd2 && $past(cls_done) && $past(cls_code) <= 4'd8));

    // R4
    class_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        class_q <= 4'd8);

    // R8
    trip_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 3'd5 && $past(state_code) != 3'd5)
            |-> (trip_cnt != $past(trip_cnt) || trip_cnt == '1));

    // R12
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (trip_cnt >= $past(trip_cnt) && retry_cnt >= $past(retry_cnt)
                  && det_fail_cnt >= $past(det_fail_cnt)));

    // R2
    state_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_code <= 3'd5);

endmodule

bind poe_port_seq poe_port_seq_chk #(.CNT_W(CNT_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .port_en      (port_en),
    .cls_done     (cls_done),
    .cls_code     (cls_code),
    .gate_on      (gate_on),
    .ilim_high    (ilim_high),
    .state_code   (state_code),
    .class_q      (class_q),
    .det_fail_cnt (det_fail_cnt),
    .trip_cnt     (trip_cnt),
    .retry_cnt    (retry_cnt)
);

// File: tb/poe_port_seq_tb_top.sv
module poe_port_seq_tb_top;

    localparam int CW = 3;
    localparam int SAT = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic port_en = 1'b0, det_done = 1'b0, det_ok = 1'b0, cls_done = 1'b0;
    logic [3:0] cls_code = 4'd0;
    logic cls_two_event = 1'b0, oc_trip = 1'b0, mps_seen = 1'b0;
    logic grant_valid = 1'b0, grant_ok = 1'b0, fault_clear = 1'b0, retry_mode = 1'b1;
    logic gate_on, ilim_high, two_event_q;
    logic [2:0] state_code, last_fail;
    logic [3:0] class_q;
    logic [1:0] off_reason;
    logic [CW-1:0] det_fail_cnt, cls_fail_cnt, trip_cnt, retry_cnt;

    int total = 0;
    int bad = 0;
    int exp_det = 0, exp_cls = 0, exp_trip = 0, exp_retry = 0;

    always #5 clk = ~clk;

    poe_port_seq #(
        .CNT_W(CW), .INRUSH_TICKS(4), .MPS_WIN_TICKS(6),
        .RETRY_TICKS(5), .MAX_RETRY(2)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .port_en(port_en), .det_done(det_done),
        .det_ok(det_ok), .cls_done(cls_done), .cls_code(cls_code),
        .cls_two_event(cls_two_event), .oc_trip(oc_trip), .mps_seen(mps_seen),
        .grant_valid(grant_valid), .grant_ok(grant_ok), .fault_clear(fault_clear),
        .retry_mode(retry_mode), .gate_on(gate_on), .ilim_high(ilim_high),
        .state_code(state_code), .class_q(class_q), .two_event_q(two_event_q),
        .last_fail(last_fail), .off_reason(off_reason), .det_fail_cnt(det_fail_cnt),
        .cls_fail_cnt(cls_fail_cnt), .trip_cnt(trip_cnt), .retry_cnt(retry_cnt)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int sat(input int v);
        return (v > SAT) ? SAT : v;
    endfunction

    task automatic check_counters(input string req);
        chk(req, "det_fail_cnt", int'(det_fail_cnt), sat(exp_det));
        chk(req, "cls_fail_cnt", int'(cls_fail_cnt), sat(exp_cls));
        chk(req, "trip_cnt", int'(trip_cnt), sat(exp_trip));
        chk(req, "retry_cnt", int'(retry_cnt), sat(exp_retry));
    endtask

    task automatic detect_pass();
        det_done = 1'b1; det_ok = 1'b1;
        step();
        det_done = 1'b0; det_ok = 1'b0;
        chk("R2", "state after detect pass", int'(state_code), 2);
    endtask

    task automatic classify(input int code, input logic two);
        cls_done = 1'b1; cls_code = 4'(code); cls_two_event = two;
        step();
        cls_done = 1'b0; cls_two_event = 1'b0;
        chk("R4", "state after class", int'(state_code), 3);
        chk("R4", "class_q", int'(class_q), code);
        chk("R4", "two_event_q", int'(two_event_q), int'(two));
        chk("R5", "gate before grant", int'(gate_on), 0);
    endtask

    task automatic grant_accept();
        grant_valid = 1'b1; grant_ok = 1'b1;
        step();
        grant_valid = 1'b0; grant_ok = 1'b0;
        chk("R5", "gate after grant", int'(gate_on), 1);
        chk("R6", "ilim first inrush cycle", int'(ilim_high), 1);
    endtask

    task automatic power_up(input int code, input logic two);
        detect_pass();
        classify(code, two);
        grant_accept();
        for (int i = 0; i < 3; i++) begin
            step();
            chk("R6", "ilim within inrush", int'(ilim_high), 1);
            chk("R6", "state within inrush", int'(state_code), 3);
        end
        step();
        chk("R6", "state after inrush", int'(state_code), 4);
        chk("R6", "ilim after inrush", int'(ilim_high), 0);
        chk("R6", "gate after inrush", int'(gate_on), 1);
    endtask

    task automatic trip(input int where);
        oc_trip = 1'b1;
        step();
        oc_trip = 1'b0;
        exp_trip++;
        chk("R8", "state after trip", int'(state_code), 5);
        chk("R8", "gate after trip", int'(gate_on), 0);
        chk("R8", "last_fail after trip", int'(last_fail), where);
        chk("R8", "off_reason overload", int'(off_reason), 2);
        check_counters("R8");
    endtask

    task automatic expect_retry();
        for (int i = 0; i < 4; i++) begin
            step();
            chk("R9", "held in fault", int'(state_code), 5);
        end
        step();
        exp_retry++;
        chk("R9", "state after retry timer", int'(state_code), 1);
        check_counters("R9");
    endtask

    task automatic expect_latched();
        for (int i = 0; i < 12; i++) begin
            step();
            chk("R10", "latched fault", int'(state_code), 5);
        end
        check_counters("R10");
        fault_clear = 1'b1;
        step();
        fault_clear = 1'b0;
        chk("R10", "state after clear", int'(state_code), 0);
        step();
        chk("R2", "idle to detect", int'(state_code), 1);
    endtask

    task automatic t_reset();
        chk("R1", "state", int'(state_code), 0);
        chk("R1", "gate", int'(gate_on), 0);
        chk("R1", "ilim", int'(ilim_high), 0);
        chk("R1", "last_fail", int'(last_fail), 0);
        chk("R1", "off_reason", int'(off_reason), 0);
        check_counters("R1");
    endtask

    task automatic t_bringup_and_mps();
        port_en = 1'b1;
        step();
        chk("R2", "idle to detect", int'(state_code), 1);
        power_up(4, 1'b1);
        for (int i = 0; i < 4; i++) step();
        mps_seen = 1'b1;
        step();
        mps_seen = 1'b0;
        for (int i = 0; i < 5; i++) begin
            step();
            chk("R7", "window restarted", int'(state_code), 4);
        end
        step();
        chk("R7", "state after loss", int'(state_code), 0);
        chk("R7", "gate after loss", int'(gate_on), 0);
        chk("R7", "off_reason lost", int'(off_reason), 1);
        chk("R7", "last_fail lost", int'(last_fail), 4);
        step();
    endtask

    task automatic t_detect_fail();
        det_done = 1'b1; det_ok = 1'b0;
        step();
        det_done = 1'b0;
        exp_det++;
        chk("R3", "state", int'(state_code), 0);
        chk("R3", "last_fail", int'(last_fail), 1);
        check_counters("R3");
        step();
    endtask

    task automatic t_class_fail();
        detect_pass();
        cls_done = 1'b1; cls_code = 4'd9;
        step();
        cls_done = 1'b0;
        exp_cls++;
        chk("R4", "state after bad class", int'(state_code), 0);
        chk("R4", "last_fail bad class", int'(last_fail), 2);
        chk("R4", "class_q kept", int'(class_q), 4);
        check_counters("R4");
        step();
    endtask

    task automatic t_grant_refused();
        detect_pass();
        classify(3, 1'b0);
        for (int i = 0; i < 3; i++) begin
            step();
            chk("R5", "waiting for grant", int'(state_code), 3);
            chk("R5", "gate while waiting", int'(gate_on), 0);
        end
        grant_valid = 1'b1; grant_ok = 1'b0;
        step();
        grant_valid = 1'b0;
        chk("R5", "state after refusal", int'(state_code), 0);
        chk("R5", "last_fail refusal", int'(last_fail), 3);
        chk("R5", "off_reason denied", int'(off_reason), 3);
        chk("R5", "gate after refusal", int'(gate_on), 0);
        step();
    endtask

    task automatic t_retry_path();
        detect_pass();
        classify(2, 1'b0);
        grant_accept();
        step();
        trip(3);
        expect_retry();
        power_up(8, 1'b0);
        trip(4);
        expect_retry();
    endtask

    task automatic t_latch_paths();
        power_up(5, 1'b1);
        trip(4);
        expect_latched();
        power_up(5, 1'b1);
        trip(4);
        expect_retry();
        retry_mode = 1'b0;
        power_up(1, 1'b0);
        trip(4);
        expect_latched();
        retry_mode = 1'b1;
    endtask

    task automatic t_disable();
        power_up(6, 1'b0);
        port_en = 1'b0;
        step();
        chk("R11", "state on disable", int'(state_code), 0);
        chk("R11", "gate on disable", int'(gate_on), 0);
        step();
        step();
        chk("R11", "held idle", int'(state_code), 0);
        port_en = 1'b1;
        step();
        chk("R11", "resume detect", int'(state_code), 1);
    endtask

    task automatic t_saturation();
        for (int i = 0; i < 9; i++) begin
            det_done = 1'b1; det_ok = 1'b0;
            step();
            det_done = 1'b0;
            exp_det++;
            step();
        end
        chk("R12", "det_fail_cnt saturated", int'(det_fail_cnt), SAT);
        check_counters("R12");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        step();
        step();
        step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_bringup_and_mps();
        t_detect_fail();
        t_class_fail();
        t_grant_refused();
        t_retry_path();
        t_latch_paths();
        t_disable();
        t_saturation();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule